// File: doc/BRIEF.md
# Serial Field-Memory Write Port Controller

This block is the write side of a serial field memory, which works like a long digital delay line. On each rising edge of the write clock it takes one 4-bit word, gated by a write enable. A write address pointer places each word. Words collect in a staging register that holds one half of a storage row (256 words). When a half fills, it is handed to a row-organized storage array in one wide store. A write-reset strobe clears the pointer. The same strobe flushes a partly filled half so that the last words of a field reach storage.

The block also watches two usage rules and raises sticky flags when they are broken. The first rule is the minimum number of active writes between resets. The second is the minimum number of quiet clock edges after a reset before the next one. The storage array sits outside the block and receives the store strobe, the address, the data and a per-word valid mask. A row-count parameter shrinks the address space for simulation.

Top module: `fieldmem_wr_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `wr_ptr` is 0, `st_valid` is 0 and both error flags are 0.
- R2: On a clock edge with `wr_rst` low and `wr_en` high, `din` is captured and `wr_ptr` advances by one.
- R3: On a clock edge with `wr_rst` low and `wr_en` low, `din` is ignored (it never appears in any store) and `wr_ptr` keeps its value, for any number of edges.
- R4: On every clock edge at which `wr_rst` is sampled high, `wr_ptr` becomes 0 and `din` is not captured, whatever the level of `wr_en`.
- R5: Pointer layout: bits [7:0] give the word within a half, bit 8 selects the half (0 = low, 1 = high), and the bits above give the row. After the last address the pointer wraps to 0.
- R6: When the word at position 255 of a half is captured, `st_valid` is high for exactly the one cycle after that edge. It carries that word's row and half and a mask of all ones.
- R7: On a reset edge with at least one captured word still staged, `st_valid` pulses in the next cycle with the staged row and half. Its mask bit i is set exactly for the positions captured since the last store. With nothing staged, no store occurs.
- R8: A reset edge preceded by fewer than 2 edges with `wr_rst` low since the previous reset sets `err_gap`. The flag stays set until `rst_n`. The first reset after `rst_n` is never a gap violation.
- R9: A reset edge that ends a segment with fewer than 130 captured words sets `err_short`. The flag stays set until `rst_n`. The segment before the first reset after `rst_n` is exempt.
- R10: In a store, the word for position i sits at `st_data[4*i+3:4*i]`, so storage ends up holding every captured word at its pointer address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Write enable |
| wr_rst | input | 1 | Write-reset strobe, sampled on the clock |
| din | input | 4 | Input word |
| wr_ptr | output | ROW_BITS+9 | Current write address pointer |
| st_valid | output | 1 | One-cycle store strobe toward the array |
| st_row | output | ROW_BITS | Row address of the store |
| st_half | output | 1 | Half select of the store |
| st_data | output | 1024 | 256 words of store data |
| st_mask | output | 256 | Per-word valid mask of the store |
| err_gap | output | 1 | Sticky reset-spacing violation flag |
| err_short | output | 1 | Sticky short-segment violation flag |

## Verification
A wrong pointer shows on `wr_ptr` in the cycle after the faulty edge. It also places data at the wrong address, so the final comparison of storage against the reference field catches it. A stale or lost staged word, or a mask bit set in error, shows in the store that closes its half: at most 256 active edges later, or at the next reset. A wrong rule counter shows on a flag at the first reset edge whose verdict it changes. Constrained random enable patterns are mixed with a full wrap of the scaled address space and with deliberate rule violations.

// File: rtl/fmw_pkg.sv
`timescale 1ns/1ps
package fmw_pkg;
    localparam int WORD_W    = 4;
    localparam int HALF_LOG2 = 8;
    localparam int HALF_WORDS = 1 << HALF_LOG2;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fmw_ptr.sv
`timescale 1ns/1ps
module fmw_ptr #(
    parameter int ROW_BITS  = 9,
    parameter int HALF_LOG2 = 8,
    localparam int PW = ROW_BITS + 1 + HALF_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_rst,
    output logic [PW-1:0] ptr,
    output logic          cap,
    output logic          half_end
);
    typedef struct packed {
        logic [PW-1:0] ptr;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        cap      = wr_en && !wr_rst;
        half_end = cap && (&s_q.ptr[HALF_LOG2-1:0]);
        if (wr_rst) begin
            s_d.ptr = '0;
        end else if (wr_en) begin
            s_d.ptr = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr = s_q.ptr;

    assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> (ptr == '0));
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rst && wr_en && !(&ptr)) |=> (ptr == $past(ptr) + 1'b1));
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rst && !wr_en) |=> $stable(ptr));
    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rst && wr_en && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/fmw_halfbuf.sv
`timescale 1ns/1ps
module fmw_halfbuf
    import fmw_pkg::*;
#(
    parameter int ROW_BITS = 9,
    localparam int PW = ROW_BITS + 1 + HALF_LOG2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap,
    input  logic                          flush,
    input  word_t                         din,
    input  logic [PW-1:0]                 ptr,
    output logic                          st_valid,
    output logic [ROW_BITS-1:0]           st_row,
    output logic                          st_half,
    output logic [HALF_WORDS*WORD_W-1:0]  st_data,
    output logic [HALF_WORDS-1:0]         st_mask
);
    typedef struct packed {
        logic [HALF_WORDS-1:0][WORD_W-1:0] data;
        logic [HALF_WORDS-1:0]             mask;
        logic                              st_valid;
        logic [ROW_BITS-1:0]               st_row;
        logic                              st_half;
        logic [HALF_WORDS-1:0][WORD_W-1:0] st_data;
        logic [HALF_WORDS-1:0]             st_mask;
    } state_t;

    state_t s_d, s_q;
    logic [HALF_LOG2-1:0] idx;
    logic [HALF_WORDS-1:0][WORD_W-1:0] data_ins;
    logic [HALF_WORDS-1:0] mask_ins;

    assign idx = ptr[HALF_LOG2-1:0];

    always_comb begin
        data_ins      = s_q.data;
        data_ins[idx] = din;
        mask_ins      = s_q.mask;
        mask_ins[idx] = 1'b1;
    end

    always_comb begin
        s_d          = s_q;
        s_d.st_valid = 1'b0;
        if (flush) begin
            if (|s_q.mask) begin
                s_d.st_valid = 1'b1;
                s_d.st_row   = ptr[PW-1:HALF_LOG2+1];
                s_d.st_half  = ptr[HALF_LOG2];
                s_d.st_data  = s_q.data;
                s_d.st_mask  = s_q.mask;
            end
            s_d.mask = '0;
        end else if (cap) begin
            if (&idx) begin
                s_d.st_valid = 1'b1;
                s_d.st_row   = ptr[PW-1:HALF_LOG2+1];
                s_d.st_half  = ptr[HALF_LOG2];
                s_d.st_data  = data_ins;
                s_d.st_mask  = mask_ins;
                s_d.mask     = '0;
            end else begin
                s_d.data = data_ins;
                s_d.mask = mask_ins;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_valid = s_q.st_valid;
    assign st_row   = s_q.st_row;
    assign st_half  = s_q.st_half;
    assign st_data  = s_q.st_data;
    assign st_mask  = s_q.st_mask;

    assert_full_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !$past(flush)) |-> (&st_mask));
    assert_store_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (|st_mask));
    assert_store_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !flush && !cap) |=> !st_valid);
endmodule

// File: rtl/fmw_rules.sv
`timescale 1ns/1ps
module fmw_rules #(
    parameter int MIN_SEG = 130,
    parameter int MIN_GAP = 2,
    localparam int SW = $clog2(MIN_SEG + 1),
    localparam int GW = $clog2(MIN_GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic wr_rst,
    output logic err_gap,
    output logic err_short
);
    typedef struct packed {
        logic [GW-1:0] gap;
        logic [SW-1:0] seg;
        logic          armed;
        logic          err_gap;
        logic          err_short;
    } state_t;

    localparam state_t RESET_STATE = '{gap: GW'(MIN_GAP), seg: '0, armed: 1'b0,
                                       err_gap: 1'b0, err_short: 1'b0};

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_rst) begin
            if (s_q.gap < GW'(MIN_GAP))                 s_d.err_gap   = 1'b1;
            if (s_q.armed && s_q.seg < SW'(MIN_SEG))    s_d.err_short = 1'b1;
            s_d.armed = 1'b1;
            s_d.gap   = '0;
            s_d.seg   = '0;
        end else begin
            if (s_q.gap < GW'(MIN_GAP)) s_d.gap = s_q.gap + 1'b1;
            if (cap && s_q.seg < SW'(MIN_SEG)) s_d.seg = s_q.seg + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign err_gap   = s_q.err_gap;
    assign err_short = s_q.err_short;

    assert_gap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_gap |=> err_gap);
    assert_short_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> err_short);
    assert_gap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_gap) |-> $past(wr_rst));
    assert_short_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_short) |-> $past(wr_rst));
endmodule

// File: rtl/fieldmem_wr_ctrl.sv
`timescale 1ns/1ps
module fieldmem_wr_ctrl
    import fmw_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int MIN_SEG  = 130,
    parameter int MIN_GAP  = 2,
    localparam int PW = ROW_BITS + 1 + HALF_LOG2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_rst,
    input  logic [WORD_W-1:0]             din,
    output logic [PW-1:0]                 wr_ptr,
    output logic                          st_valid,
    output logic [ROW_BITS-1:0]           st_row,
    output logic                          st_half,
    output logic [HALF_WORDS*WORD_W-1:0]  st_data,
    output logic [HALF_WORDS-1:0]         st_mask,
    output logic                          err_gap,
    output logic                          err_short
);
    logic cap;
    logic half_end;

    fmw_ptr #(.ROW_BITS(ROW_BITS), .HALF_LOG2(HALF_LOG2)) i_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rst(wr_rst),
        .ptr(wr_ptr), .cap(cap), .half_end(half_end)
    );

    fmw_halfbuf #(.ROW_BITS(ROW_BITS)) i_buf (
        .clk(clk), .rst_n(rst_n), .cap(cap), .flush(wr_rst), .din(din),
        .ptr(wr_ptr), .st_valid(st_valid), .st_row(st_row), .st_half(st_half),
        .st_data(st_data), .st_mask(st_mask)
    );

    fmw_rules #(.MIN_SEG(MIN_SEG), .MIN_GAP(MIN_GAP)) i_rules (
        .clk(clk), .rst_n(rst_n), .cap(cap), .wr_rst(wr_rst),
        .err_gap(err_gap), .err_short(err_short)
    );

    assert_half_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        half_end |=> (st_valid && st_row == $past(wr_ptr[PW-1:HALF_LOG2+1])
                      && st_half == $past(wr_ptr[HALF_LOG2])));
    assert_store_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ($past(wr_rst) || $past(half_end)));
endmodule

// File: tb/test_fieldmem_wr_ctrl.sv
`timescale 1ns/1ps
module test_fieldmem_wr_ctrl;
    localparam int RB = 2;
    localparam int HL = 8;
    localparam int HW = 256;
    localparam int PW = RB + 1 + HL;
    localparam int DEPTH = 1 << PW;
    localparam int MIN_SEG = 130;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_rst = 1'b0;
    logic [3:0] din = '0;
    logic [PW-1:0] wr_ptr;
    logic st_valid;
    logic [RB-1:0] st_row;
    logic st_half;
    logic [HW*4-1:0] st_data;
    logic [HW-1:0] st_mask;
    logic err_gap, err_short;

    always #2 clk = ~clk;

    fieldmem_wr_ctrl #(.ROW_BITS(RB)) i_fieldmem_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rst(wr_rst), .din(din),
        .wr_ptr(wr_ptr), .st_valid(st_valid), .st_row(st_row), .st_half(st_half),
        .st_data(st_data), .st_mask(st_mask), .err_gap(err_gap), .err_short(err_short)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [3:0] ref_mem [DEPTH];
    logic [3:0] got_mem [DEPTH];

    logic [PW-1:0] m_ptr = '0;
    logic [HW-1:0] m_mask = '0;
    int  m_gap = 2;
    int  m_seg = 0;
    bit  m_armed = 0;
    bit  m_eg = 0;
    bit  m_es = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // one clock edge: drive at a falling edge, check at the next falling edge
    task automatic step(input bit en, input bit rs, input logic [3:0] d, input string tag);
        bit exp_st;
        logic [HW-1:0] exp_msk;
        logic [RB:0] exp_rh;
        exp_st = 0;
        exp_msk = '0;
        exp_rh = '0;
        wr_en = en;
        wr_rst = rs;
        din = d;
        @(negedge clk);
        if (rs) begin
            if (|m_mask) begin
                exp_st = 1; exp_msk = m_mask; exp_rh = m_ptr[PW-1:HL];
            end
            if (m_gap < 2) m_eg = 1;
            if (m_armed && m_seg < MIN_SEG) m_es = 1;
            m_armed = 1; m_gap = 0; m_seg = 0; m_ptr = '0; m_mask = '0;
        end else begin
            if (m_gap < 2) m_gap++;
            if (en) begin
                ref_mem[m_ptr] = d;
                m_mask[m_ptr[HL-1:0]] = 1'b1;
                if (m_seg < MIN_SEG) m_seg++;
                if (&m_ptr[HL-1:0]) begin
                    exp_st = 1; exp_msk = m_mask; exp_rh = m_ptr[PW-1:HL];
                    m_mask = '0;
                end
                m_ptr = m_ptr + 1'b1;
            end
        end
        chk(wr_ptr == m_ptr, tag, "pointer", wr_ptr, m_ptr);
        chk(st_valid == exp_st, "R6", "store strobe", st_valid, exp_st);
        if (st_valid && exp_st) begin
            chk(st_mask == exp_msk, "R7", "mask popcount", $countones(st_mask), $countones(exp_msk));
            chk({st_row, st_half} == exp_rh, "R5", "row/half", {st_row, st_half}, exp_rh);
        end
        chk(err_gap == m_eg, "R8", "err_gap", err_gap, m_eg);
        chk(err_short == m_es, "R9", "err_short", err_short, m_es);
        if (st_valid) begin
            for (int i = 0; i < HW; i++) begin
                if (st_mask[i]) got_mem[{st_row, st_half, i[HL-1:0]}] = st_data[i*4 +: 4];
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int bad;
        void'($urandom(32'h5eed_1234));
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = '0;
            got_mem[a] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(wr_ptr == '0, "R1", "pointer after reset", wr_ptr, 0);
        chk(!st_valid, "R1", "store after reset", st_valid, 0);
        chk(!err_gap && !err_short, "R1", "flags after reset", {err_gap, err_short}, 0);

        // first reset is exempt, empty buffer gives no store (R7), enable overridden (R4)
        step(1, 1, 4'hA, "R4");
        chk(!err_short, "R9", "first reset exempt", err_short, 0);
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");

        // random enable pattern
        for (int k = 0; k < 700; k++)
            step(($urandom % 10) < 7, 0, 4'($urandom), "R2");
        // long enable-low stretch, data must be ignored
        for (int k = 0; k < 40; k++)
            step(0, 0, 4'($urandom), "R3");
        // reset with partial half staged: flush, enable ignored
        step(1, 1, 4'h5, "R4");
        chk(!err_gap && !err_short, "R9", "legal segment", {err_gap, err_short}, 0);
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");

        // full pass through address space with wrap
        for (int k = 0; k < DEPTH + 100; k++)
            step(1, 0, 4'($urandom), "R5");
        step(0, 0, 0, "R3");
        step(0, 1, 0, "R4");
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");

        // short segment violation
        for (int k = 0; k < 10; k++)
            step(1, 0, 4'($urandom), "R2");
        step(0, 1, 0, "R4");
        chk(err_short, "R9", "short segment flagged", err_short, 1);
        chk(!err_gap, "R8", "spacing still legal", err_gap, 0);
        // back-to-back reset violates spacing
        step(0, 1, 0, "R4");
        chk(err_gap, "R8", "spacing violation flagged", err_gap, 1);
        for (int k = 0; k < 5; k++)
            step(($urandom % 2) == 1, 0, 4'($urandom), "R2");
        chk(err_gap && err_short, "R8", "flags sticky", {err_gap, err_short}, 3);
        step(0, 0, 0, "R3");
        step(0, 1, 0, "R4");

        // storage contents versus reference field
        bad = 0;
        for (int a = 0; a < DEPTH; a++)
            if (got_mem[a] !== ref_mem[a]) bad++;
        chk(bad == 0, "R10", "storage mismatches", bad, 0);
        finish_run();
    end
endmodule